// File: doc/BRIEF.md
# Software-Forced DRAM Command Issuer

This block lets software push a single SDRAM command onto the DRAM command bus. A control word is written through a plain register port. One of three request bits in that word chooses the command: a mode-register load, a refresh, or a precharge. Other fields pick the target chip select, pick which mode register or bank is meant, and say whether a precharge covers all banks. For a mode-register load, the data comes from a separate 16-bit mode value input.

While a request bit is set, the block raises a request toward the DRAM command arbiter. In the cycle where the arbiter grants, the block drives the command onto active-low chip-select, RAS, CAS and WE, bank address and address lines for exactly that cycle. The request bit clears on the clock edge that ends the grant cycle. At all other times the bus shows a NOP with every chip select deasserted. A write that tries to set more than one request bit at once is refused, and a sticky error flag records the refusal.

Top module: `dram_force_cmd`

## Requirements
- R1: After reset the control word reads 0, cmdReq and cmdErr are low, all csN bits and rasN/casN/weN are high, and bankAddr and addr are 0.
- R2: A write stores the control word, which reads back with this layout: bit 0 = mode-load request, bits 3:2 = chip-select index, bits 7:5 = select field, bit 8 = refresh request, bit 9 = precharge request, bit 10 = all-banks flag. Bits 1 and 4 always read 0.
- R3: A write whose data has more than one of bits 0, 8 and 9 set leaves the control word unchanged and sets cmdErr. cmdErr stays high until reset.
- R4: cmdReq is high exactly when one of bits 0, 8 or 9 of the stored word is set. While cmdGrant is low, the bus stays at NOP even if a request is pending.
- R5: In a cycle with cmdReq and cmdGrant both high, exactly one chip select is driven low: csN[k] with k equal to the chip-select index (00 gives CS0 through 11 gives CS3).
- R6: A granted mode-load drives rasN/casN/weN = 0/0/0, bankAddr = select field (000 MR, 001 EMR, 010 EMR2, 011 EMR3), and addr = modeValue.
- R7: A granted refresh drives rasN/casN/weN = 0/0/1 with bankAddr = 0 and addr = 0, whatever the select field holds.
- R8: A granted precharge drives rasN/casN/weN = 0/1/0. If the all-banks flag is 0, bankAddr = select field and addr = 0. If the flag is 1, addr has only bit 10 set and bankAddr = 0.
- R9: On the edge that ends a grant cycle, the request bit clears and every other field is kept. cmdReq is low from the next cycle on.
- R10: cmdGrant with no pending request leaves the bus at NOP and the control word unchanged.
- R11: A valid write in the same cycle as a grant replaces the control word with the written data, and the hardware clear does not apply to that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 11 | Control word write data |
| regRdData | output | 11 | Control word read data |
| modeValue | input | ADDR_W (16) | Data for mode-register loads |
| cmdReq | output | 1 | A forced command is pending |
| cmdGrant | input | 1 | Arbiter grants the bus this cycle |
| cmdErr | output | 1 | Sticky flag for a refused multi-request write |
| csN | output | 4 | Active-low chip selects |
| rasN | output | 1 | Active-low row strobe |
| casN | output | 1 | Active-low column strobe |
| weN | output | 1 | Active-low write enable |
| bankAddr | output | 3 | Bank address |
| addr | output | ADDR_W (16) | Address lines |

## Verification
The bench builds the block with its defaults: a 16-bit address and the all-banks marker at address bit 10. This lets every chip-select index and every select-field value be driven onto real pins, and it lets the all-banks precharge be told apart from a single-bank precharge by a single address bit. A mode value of all ones is applied to show that the full address width follows the input. Writes that overlap a grant, and grants with nothing pending, are within reach at these values without any extra widths.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int CTRL_W   = 11;
  localparam int CS_W     = 2;
  localparam int SEL_W    = 3;
  localparam int NUM_CS   = 1 << CS_W;

  localparam int MODE_BIT = 0;
  localparam int CS_LSB   = 2;
  localparam int SEL_LSB  = 5;
  localparam int REF_BIT  = 8;
  localparam int PRE_BIT  = 9;
  localparam int ALL_BIT  = 10;

  localparam logic [CTRL_W-1:0] REQ_MASK =
    (CTRL_W'(1) << MODE_BIT) | (CTRL_W'(1) << REF_BIT) | (CTRL_W'(1) << PRE_BIT);
  localparam logic [CTRL_W-1:0] WR_MASK =
    REQ_MASK | (CTRL_W'(1) << ALL_BIT) |
    (CTRL_W'((1 << CS_W) - 1) << CS_LSB) | (CTRL_W'((1 << SEL_W) - 1) << SEL_LSB);

  typedef struct packed {
    logic             fire;
    logic             doMrs;
    logic             doRef;
    logic             doPre;
    logic             allBanks;
    logic [CS_W-1:0]  csSel;
    logic [SEL_W-1:0] sel;
  } dfc_strobe_t;

  function automatic logic [1:0] reqCount(input logic [CTRL_W-1:0] w);
    return {1'b0, w[MODE_BIT]} + {1'b0, w[REF_BIT]} + {1'b0, w[PRE_BIT]};
  endfunction
endpackage

// File: rtl/dfc_ctrl.sv
module dfc_ctrl
  import dfc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              cmdGrant,
  output logic [CTRL_W-1:0] regRdData,
  output logic              cmdReq,
  output logic              cmdErr,
  output dfc_strobe_t       strobe
);
  logic [CTRL_W-1:0] ctrlQ;
  logic              errQ;
  logic              multiReq;
  logic              fire;

  assign multiReq = (reqCount(regWrData) > 2'd1);
  assign cmdReq   = |(ctrlQ & REQ_MASK);
  assign fire     = cmdReq && cmdGrant;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (regWrEn && !multiReq) begin
        ctrlQ <= regWrData & WR_MASK;
      end else if (fire) begin
        ctrlQ <= ctrlQ & ~REQ_MASK;
      end
      if (regWrEn && multiReq) begin
        errQ <= 1'b1;
      end
    end
  end

  assign regRdData = ctrlQ;
  assign cmdErr    = errQ;

  always_comb begin
    strobe.fire     = fire;
    strobe.doMrs    = ctrlQ[MODE_BIT];
    strobe.doRef    = ctrlQ[REF_BIT];
    strobe.doPre    = ctrlQ[PRE_BIT];
    strobe.allBanks = ctrlQ[ALL_BIT];
    strobe.csSel    = ctrlQ[CS_LSB +: CS_W];
    strobe.sel      = ctrlQ[SEL_LSB +: SEL_W];
  end
endmodule

// File: rtl/dfc_datapath.sv
module dfc_datapath
  import dfc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PRE_ALL_POS = 10
) (
  input  dfc_strobe_t       strobe,
  input  logic [ADDR_W-1:0] modeValue,
  output logic [NUM_CS-1:0] csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [SEL_W-1:0]  bankAddr,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ALL_MARK = ADDR_W'(1) << PRE_ALL_POS;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(strobe.fire && (strobe.csSel == CS_W'(i)));
  end

  always_comb begin
    rasN     = 1'b1;
    casN     = 1'b1;
    weN      = 1'b1;
    bankAddr = '0;
    addr     = '0;
    if (strobe.fire) begin
      if (strobe.doMrs) begin
        rasN     = 1'b0;
        casN     = 1'b0;
        weN      = 1'b0;
        bankAddr = strobe.sel;
        addr     = modeValue;
      end else if (strobe.doRef) begin
        rasN = 1'b0;
        casN = 1'b0;
      end else if (strobe.doPre) begin
        rasN = 1'b0;
        weN  = 1'b0;
        if (strobe.allBanks) begin
          addr = ALL_MARK;
        end else begin
          bankAddr = strobe.sel;
        end
      end
    end
  end
endmodule

// File: rtl/dram_force_cmd.sv
module dram_force_cmd
  import dfc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PRE_ALL_POS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] modeValue,
  output logic              cmdReq,
  input  logic              cmdGrant,
  output logic              cmdErr,
  output logic [NUM_CS-1:0] csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [SEL_W-1:0]  bankAddr,
  output logic [ADDR_W-1:0] addr
);
  dfc_strobe_t strobe;

  dfc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .cmdGrant  (cmdGrant),
    .regRdData (regRdData),
    .cmdReq    (cmdReq),
    .cmdErr    (cmdErr),
    .strobe    (strobe)
  );

  dfc_datapath #(.ADDR_W(ADDR_W), .PRE_ALL_POS(PRE_ALL_POS)) u_dp (
    .strobe    (strobe),
    .modeValue (modeValue),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .bankAddr  (bankAddr),
    .addr      (addr)
  );
endmodule

// File: rtl/dfc_chk.sv
module dfc_chk
  import dfc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [CTRL_W-1:0] regWrData,
  input logic [CTRL_W-1:0] regRdData,
  input logic              cmdReq,
  input logic              cmdGrant,
  input logic              cmdErr,
  input logic [NUM_CS-1:0] csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [SEL_W-1:0]  bankAddr,
  input logic [ADDR_W-1:0] addr
);
  logic granted;
  assign granted = cmdReq && cmdGrant;

  // R4
  req_matches_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq == (regRdData[MODE_BIT] | regRdData[REF_BIT] | regRdData[PRE_BIT]));

  // R3
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({regRdData[MODE_BIT], regRdData[REF_BIT], regRdData[PRE_BIT]}) <= 1);

  // R4
  nop_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !granted |-> (&csN && rasN && casN && weN));

  // R5
  one_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    granted |-> $countones(~csN) == 1);

  // R9
  clear_after_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (granted && !regWrEn) |=> !cmdReq);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);

  // R3
  reject_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !granted &&
     $countones({regWrData[MODE_BIT], regWrData[REF_BIT], regWrData[PRE_BIT]}) > 1)
    |=> ($stable(regRdData) && cmdErr));

  // R7
  refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (granted && !rasN && !casN && weN) |-> (bankAddr == '0 && addr == '0));
endmodule

bind dram_force_cmd dfc_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dram_force_cmd.sv
`timescale 1ns/1ps
module sim_dram_force_cmd;
  import dfc_pkg::*;

  localparam int ADDR_W = 16;
  localparam logic [CTRL_W-1:0] RD_MASK  = 11'h7ED;
  localparam logic [CTRL_W-1:0] REQ_BITS = 11'h301;

  typedef struct packed {
    logic [CTRL_W-1:0] wr;
    logic [ADDR_W-1:0] mv;
    logic [3:0]        cs;
    logic [2:0]        rcw;
    logic [2:0]        ba;
    logic [ADDR_W-1:0] ad;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{11'h001, 16'h0532, 4'b1110, 3'b000, 3'd0, 16'h0532},
    '{11'h025, 16'h0044, 4'b1101, 3'b000, 3'd1, 16'h0044},
    '{11'h049, 16'h0080, 4'b1011, 3'b000, 3'd2, 16'h0080},
    '{11'h06D, 16'hFFFF, 4'b0111, 3'b000, 3'd3, 16'hFFFF},
    '{11'h1A8, 16'h1234, 4'b1011, 3'b001, 3'd0, 16'h0000},
    '{11'h2C4, 16'h1234, 4'b1101, 3'b010, 3'd6, 16'h0000},
    '{11'h6EC, 16'h1234, 4'b0111, 3'b010, 3'd0, 16'h0400},
    '{11'h013, 16'h0ABC, 4'b1110, 3'b000, 3'd0, 16'h0ABC}
  };

  logic              clk = 0;
  logic              rstN = 0;
  logic              regWrEn = 0;
  logic [CTRL_W-1:0] regWrData = '0;
  logic [CTRL_W-1:0] regRdData;
  logic [ADDR_W-1:0] modeValue = '0;
  logic              cmdReq;
  logic              cmdGrant = 0;
  logic              cmdErr;
  logic [3:0]        csN;
  logic              rasN, casN, weN;
  logic [2:0]        bankAddr;
  logic [ADDR_W-1:0] addr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  dram_force_cmd u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkNop(input string req);
    check(req, {16'h0, csN, rasN, casN, weN, bankAddr, 6'h0}, {16'h0, 4'hF, 3'b111, 3'b000, 6'h0});
    check(req, 32'(addr), 32'h0);
  endtask

  task automatic wrWord(input logic [CTRL_W-1:0] w);
    @(negedge clk);
    regWrEn = 1; regWrData = w;
    @(negedge clk);
    regWrEn = 0;
    #1;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", 32'(regRdData), 32'h0);
    check("R1", {cmdReq, cmdErr}, 2'b00);
    checkNop("R1");
    @(negedge clk); rstN = 1;
    #1;

    // R10 grant with nothing pending
    @(negedge clk); cmdGrant = 1; #1;
    checkNop("R10");
    @(negedge clk); cmdGrant = 0; #1;
    check("R10", 32'(regRdData), 32'h0);

    // Vector walk: R2, R5, R6, R7, R8, R9
    foreach (VECS[i]) begin
      modeValue = VECS[i].mv;
      wrWord(VECS[i].wr);
      check("R2", 32'(regRdData), 32'(VECS[i].wr & RD_MASK));
      check("R4", 32'(cmdReq), 32'h1);
      checkNop("R4");
      @(negedge clk); cmdGrant = 1; #1;
      check("R5", 32'(csN), 32'(VECS[i].cs));
      check("R6/R7/R8 cmd", 32'({rasN, casN, weN}), 32'(VECS[i].rcw));
      check("R6/R7/R8 bank", 32'(bankAddr), 32'(VECS[i].ba));
      check("R6/R7/R8 addr", 32'(addr), 32'(VECS[i].ad));
      @(negedge clk); cmdGrant = 0; #1;
      check("R9", 32'(cmdReq), 32'h0);
      check("R9", 32'(regRdData), 32'(VECS[i].wr & RD_MASK & ~REQ_BITS));
      checkNop("R9");
    end

    // R3 refused multi-request write
    check("R3", 32'(cmdErr), 32'h0);
    wrWord(11'h0A1);
    check("R3", 32'(regRdData), 32'h0A1);
    wrWord(11'h101);
    check("R3", 32'(regRdData), 32'h0A1);
    check("R3", 32'(cmdErr), 32'h1);
    wrWord(11'h301);
    check("R3", 32'(regRdData), 32'h0A1);
    wrWord(11'h008);
    check("R3", 32'(cmdErr), 32'h1);
    check("R3", 32'(regRdData), 32'h008);

    // R11 write overlapping a grant
    wrWord(11'h100);
    @(negedge clk); cmdGrant = 1; regWrEn = 1; regWrData = 11'h2C4;
    #1;
    check("R11 issue", 32'({rasN, casN, weN}), 32'b001);
    @(negedge clk); cmdGrant = 0; regWrEn = 0; #1;
    check("R11", 32'(regRdData), 32'h2C4);
    check("R11", 32'(cmdReq), 32'h1);

    // R1 reset clears error and word
    @(negedge clk); rstN = 0;
    @(negedge clk); #1;
    check("R1", {cmdErr, cmdReq}, 2'b00);
    check("R1", 32'(regRdData), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule